// File: doc/BRIEF.md
# Oversampled Serial Receiver with Per-Character Status Queue

This block turns an asynchronous serial line into a queue of characters for a CPU. It samples the line on a 16x clock enable and checks each start bit at its midpoint. It builds characters of 5 to 8 data bits, least significant bit first, with an optional parity bit. Each finished character goes into an eight-deep queue, together with three flags of its own: parity error, framing error and break.

The CPU sees the oldest queued character and its flags directly on the outputs, and removes it with a one-cycle read strobe. The assembly register works as a ninth storage place. A character that finishes while the queue is full waits there. If another valid start bit arrives before room opens, the waiting character is dropped and a sticky overrun flag is raised. Only a separate clear strobe lowers the overrun flag.

Line faults are handled in a set way. A low stop bit gives either a framing error or a break, never both. A break takes exactly one queue slot, and the receiver then stays parked until the line goes high again. After a framing error the receiver does not wait for an idle line: a line that is still low half a bit later is taken as the start of the next start bit. Because of this, a break that begins inside a character is reported as one framing-error entry followed by one break entry.

Top module: `uart_rx_status`

## Requirements
- R1: The character length code `cfg_len` selects 5, 6, 7 or 8 data bits for codes 0, 1, 2 and 3. Bits arrive least significant first, and data bits above the selected length read as zero.
- R2: A low level seen in idle starts a start bit. The line is sampled again 8 ticks later, and if it is high there the receiver returns to idle and loads nothing.
- R3: `cfg_par` code 0 means no parity bit, 1 means even, 2 means odd, and 3 means a forced bit equal to `cfg_plvl`. When the received parity bit differs from the expected value, the entry is stored with the parity error flag set.
- R4: The stop bit is sampled at its midpoint. If it is low and at least one data bit or the parity bit was 1, the entry is stored with the framing error flag set.
- R5: If the stop bit is low and all data bits and the parity bit are 0, the entry is stored with the break flag set, zero data, and the framing error flag clear.
- R6: After a break entry, no further entry is loaded until the line has returned high, however long it stays low.
- R7: After a framing error, a line still low 8 ticks after the stop sample is taken as the start of a new start bit. A break that begins inside a character therefore yields one framing-error entry and then exactly one break entry.
- R8: The queue holds 8 entries in arrival order. `rx_ready` is high exactly while the queue is non-empty, and the data and flag outputs show the oldest entry. A pulse on `rd_en` removes that entry, and `rd_en` has no effect on an empty queue.
- R9: `fifo_full` rises when the eighth entry is written. A read while a completed ninth character is waiting moves that character in and keeps `fifo_full` high.
- R10: A validated start bit that arrives while the queue is full and a ninth character is waiting sets `overrun` and discards the waiting character with its flags. `overrun` stays set until `err_clr` is pulsed.
- R11: After reset, `rx_ready`, `fifo_full` and `overrun` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_16x | input | 1 | Sampling enable, 16 pulses per bit time |
| rxd | input | 1 | Serial input line, idle high |
| cfg_len | input | 2 | Data length code (5 + code bits) |
| cfg_par | input | 2 | Parity mode: none, even, odd, forced |
| cfg_plvl | input | 1 | Expected parity level in forced mode |
| rd_en | input | 1 | Pop strobe for the head entry |
| err_clr | input | 1 | Clears the overrun flag |
| rx_ready | output | 1 | Queue holds at least one entry |
| fifo_full | output | 1 | Queue holds 8 entries |
| overrun | output | 1 | Sticky lost-character flag |
| rd_data | output | MAX_BITS | Data of the head entry |
| rd_perr | output | 1 | Parity error flag of the head entry |
| rd_ferr | output | 1 | Framing error flag of the head entry |
| rd_brk | output | 1 | Break flag of the head entry |

## Verification
Some rules hold on every cycle, and the assertions check those:
- overrun stays set until it is cleared;
- overrun rises only while the queue is full;
- a full queue is never reported as not ready;
- a break entry at the head never carries a framing error or non-zero data.

Whether a character is assembled correctly, with the right length, parity and stop-bit sample, can only be shown by the bench's serial frames. The same holds for which character is lost on an overrun, the early resynchronisation after a framing error, and the single break entry that follows a break starting mid-character.

// File: rtl/uart_rx_pkg.sv
package uart_rx_pkg;

   typedef enum logic [1:0] {
      PAR_NONE  = 2'd0,
      PAR_EVEN  = 2'd1,
      PAR_ODD   = 2'd2,
      PAR_FORCE = 2'd3
   } par_mode_e;

   typedef enum logic [2:0] {
      RX_IDLE,
      RX_START,
      RX_DATA,
      RX_PAR,
      RX_STOP,
      RX_RESYNC,
      RX_MARK
   } rx_state_e;

   typedef struct packed {
      logic brk;
      logic ferr;
      logic perr;
   } rx_flags_t;

   localparam int FLAG_W = $bits(rx_flags_t);

endpackage

// File: rtl/uart_rx_framer.sv
module uart_rx_framer
   import uart_rx_pkg::*;
#(
   parameter int OSR         = 16,
   parameter int MAX_BITS    = 8,
   parameter int SYNC_STAGES = 2,
   parameter bit PARITY_EN   = 1'b1
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                tick,
   input  logic                rxd,
   input  logic [1:0]          cfg_len,
   input  logic [1:0]          cfg_par,
   input  logic                cfg_plvl,
   output logic                start_ok,
   output logic                char_vld,
   output logic [MAX_BITS-1:0] char_data,
   output rx_flags_t           char_flags
);

   localparam int CNT_W = $clog2(OSR);
   localparam int IDX_W = $clog2(MAX_BITS);
   localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(OSR - 1);
   localparam logic [CNT_W-1:0] CNT_HALF = CNT_W'(OSR / 2 - 1);

   generate
      if (OSR < 4 || (OSR % 2) != 0) begin : g_bad_osr
         $error("uart_rx_framer: OSR must be even and at least 4");
      end
      if (MAX_BITS < 8) begin : g_bad_bits
         $error("uart_rx_framer: MAX_BITS must cover 8-bit characters");
      end
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("uart_rx_framer: at least two synchroniser stages needed");
      end
   endgenerate

   // input synchroniser, reset to the marking level
   logic [SYNC_STAGES-1:0] sync_q;
   logic                   rx_s;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sync_q <= '1;
      else        sync_q <= {sync_q[SYNC_STAGES-2:0], rxd};
   end
   assign rx_s = sync_q[SYNC_STAGES-1];

   // parity: hardware present or removed
   logic par_on;
   logic exp_par;
   logic [MAX_BITS-1:0] shreg;

   generate
      if (PARITY_EN) begin : g_par
         assign par_on = (cfg_par != PAR_NONE);
         always_comb begin
            unique case (par_mode_e'(cfg_par))
               PAR_EVEN:  exp_par = ^shreg;
               PAR_ODD:   exp_par = ~^shreg;
               PAR_FORCE: exp_par = cfg_plvl;
               default:   exp_par = 1'b0;
            endcase
         end
      end else begin : g_nopar
         assign par_on  = 1'b0;
         assign exp_par = 1'b0;
      end
   endgenerate

   rx_state_e       st;
   logic [CNT_W-1:0] cnt;
   logic [IDX_W-1:0] idx;
   logic [IDX_W-1:0] last_idx;
   logic            pbit;
   logic            any_one;
   logic            perr_c;

   assign last_idx = IDX_W'(cfg_len) + IDX_W'(4);
   assign any_one  = (|shreg) || (par_on && pbit);
   assign perr_c   = par_on && (pbit != exp_par);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st         <= RX_IDLE;
         cnt        <= '0;
         idx        <= '0;
         shreg      <= '0;
         pbit       <= 1'b0;
         start_ok   <= 1'b0;
         char_vld   <= 1'b0;
         char_data  <= '0;
         char_flags <= '0;
      end else begin
         start_ok <= 1'b0;
         char_vld <= 1'b0;
         if (tick) begin
            unique case (st)
               RX_IDLE: begin
                  cnt <= '0;
                  if (!rx_s) st <= RX_START;
               end
               RX_START: begin
                  if (cnt == CNT_HALF) begin
                     cnt <= '0;
                     if (rx_s) begin
                        st <= RX_IDLE;
                     end else begin
                        st       <= RX_DATA;
                        idx      <= '0;
                        shreg    <= '0;
                        pbit     <= 1'b0;
                        start_ok <= 1'b1;
                     end
                  end else begin
                     cnt <= cnt + 1'b1;
                  end
               end
               RX_DATA: begin
                  if (cnt == CNT_LAST) begin
                     cnt        <= '0;
                     shreg[idx] <= rx_s;
                     if (idx == last_idx) st <= par_on ? RX_PAR : RX_STOP;
                     else                 idx <= idx + 1'b1;
                  end else begin
                     cnt <= cnt + 1'b1;
                  end
               end
               RX_PAR: begin
                  if (cnt == CNT_LAST) begin
                     cnt  <= '0;
                     pbit <= rx_s;
                     st   <= RX_STOP;
                  end else begin
                     cnt <= cnt + 1'b1;
                  end
               end
               RX_STOP: begin
                  if (cnt == CNT_LAST) begin
                     cnt             <= '0;
                     char_vld        <= 1'b1;
                     char_data       <= shreg;
                     char_flags.perr <= perr_c;
                     char_flags.ferr <= !rx_s && any_one;
                     char_flags.brk  <= !rx_s && !any_one;
                     if (rx_s)         st <= RX_IDLE;
                     else if (any_one) st <= RX_RESYNC;
                     else              st <= RX_MARK;
                  end else begin
                     cnt <= cnt + 1'b1;
                  end
               end
               RX_RESYNC: begin
                  if (cnt == CNT_HALF) begin
                     cnt <= '0;
                     st  <= rx_s ? RX_IDLE : RX_START;
                  end else begin
                     cnt <= cnt + 1'b1;
                  end
               end
               RX_MARK: begin
                  cnt <= '0;
                  if (rx_s) st <= RX_IDLE;
               end
               default: st <= RX_IDLE;
            endcase
         end
      end
   end

endmodule

// File: rtl/uart_rx_hold.sv
module uart_rx_hold
   import uart_rx_pkg::*;
#(
   parameter int W = 11
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         char_vld,
   input  logic [W-1:0] char_word,
   input  logic         start_ok,
   input  logic         q_full,
   input  logic         q_pop,
   input  logic         err_clr,
   output logic         push,
   output logic [W-1:0] push_word,
   output logic         overrun
);

   generate
      if (W <= FLAG_W) begin : g_bad_w
         $error("uart_rx_hold: entry width must exceed the flag width");
      end
   endgenerate

   logic hold_vld;
   logic ovr_evt;

   assign push    = hold_vld && (!q_full || q_pop);
   assign ovr_evt = start_ok && hold_vld && !push;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hold_vld  <= 1'b0;
         push_word <= '0;
         overrun   <= 1'b0;
      end else begin
         if (char_vld) begin
            hold_vld  <= 1'b1;
            push_word <= char_word;
         end else if (push || ovr_evt) begin
            hold_vld <= 1'b0;
         end
         if (ovr_evt)      overrun <= 1'b1;
         else if (err_clr) overrun <= 1'b0;
      end
   end

endmodule

// File: rtl/uart_rx_fifo.sv
module uart_rx_fifo #(
   parameter int W     = 11,
   parameter int DEPTH = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         push,
   input  logic [W-1:0] wdata,
   input  logic         pop,
   output logic [W-1:0] rdata,
   output logic         empty,
   output logic         full
);

   localparam int AW = $clog2(DEPTH);
   localparam int CW = AW + 1;
   localparam logic [CW-1:0] CNT_MAX = CW'(DEPTH);

   generate
      if (DEPTH < 2 || (1 << AW) != DEPTH) begin : g_bad_depth
         $error("uart_rx_fifo: DEPTH must be a power of two, at least 2");
      end
   endgenerate

   logic [W-1:0]  mem [DEPTH];
   logic [AW-1:0] wptr, rptr;
   logic [CW-1:0] count;

   assign empty = (count == '0);
   assign full  = (count == CNT_MAX);
   assign rdata = mem[rptr];

   always_ff @(posedge clk) begin
      if (push) mem[wptr] <= wdata;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wptr  <= '0;
         rptr  <= '0;
         count <= '0;
      end else begin
         if (push) wptr <= wptr + 1'b1;
         if (pop)  rptr <= rptr + 1'b1;
         unique case ({push, pop})
            2'b10:   count <= count + 1'b1;
            2'b01:   count <= count - 1'b1;
            default: count <= count;
         endcase
      end
   end

endmodule

// File: rtl/uart_rx_status.sv
module uart_rx_status
   import uart_rx_pkg::*;
#(
   parameter int OSR         = 16,
   parameter int MAX_BITS    = 8,
   parameter int DEPTH       = 8,
   parameter int SYNC_STAGES = 2,
   parameter bit PARITY_EN   = 1'b1
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                tick_16x,
   input  logic                rxd,
   input  logic [1:0]          cfg_len,
   input  logic [1:0]          cfg_par,
   input  logic                cfg_plvl,
   input  logic                rd_en,
   input  logic                err_clr,
   output logic                rx_ready,
   output logic                fifo_full,
   output logic                overrun,
   output logic [MAX_BITS-1:0] rd_data,
   output logic                rd_perr,
   output logic                rd_ferr,
   output logic                rd_brk
);

   localparam int W = MAX_BITS + FLAG_W;

   logic                start_ok, char_vld;
   logic [MAX_BITS-1:0] char_data;
   rx_flags_t           char_flags;
   logic                push, pop, q_empty, q_full;
   logic [W-1:0]        push_word, head_word;
   rx_flags_t           head_flags;

   uart_rx_framer #(
      .OSR(OSR), .MAX_BITS(MAX_BITS),
      .SYNC_STAGES(SYNC_STAGES), .PARITY_EN(PARITY_EN)
   ) u_framer (
      .clk(clk), .rst_n(rst_n), .tick(tick_16x), .rxd(rxd),
      .cfg_len(cfg_len), .cfg_par(cfg_par), .cfg_plvl(cfg_plvl),
      .start_ok(start_ok), .char_vld(char_vld),
      .char_data(char_data), .char_flags(char_flags)
   );

   uart_rx_hold #(.W(W)) u_hold (
      .clk(clk), .rst_n(rst_n), .char_vld(char_vld),
      .char_word({char_flags, char_data}), .start_ok(start_ok),
      .q_full(q_full), .q_pop(pop), .err_clr(err_clr),
      .push(push), .push_word(push_word), .overrun(overrun)
   );

   uart_rx_fifo #(.W(W), .DEPTH(DEPTH)) u_fifo (
      .clk(clk), .rst_n(rst_n), .push(push), .wdata(push_word),
      .pop(pop), .rdata(head_word), .empty(q_empty), .full(q_full)
   );

   assign pop        = rd_en && !q_empty;
   assign head_flags = rx_flags_t'(head_word[W-1:MAX_BITS]);
   assign rx_ready   = !q_empty;
   assign fifo_full  = q_full;
   assign rd_data    = head_word[MAX_BITS-1:0];
   assign rd_perr    = head_flags.perr;
   assign rd_ferr    = head_flags.ferr;
   assign rd_brk     = head_flags.brk;

endmodule

// File: rtl/uart_rx_status_chk.sv
module uart_rx_status_chk #(
   parameter int MAX_BITS = 8
) (
   input logic                clk,
   input logic                rst_n,
   input logic                err_clr,
   input logic                rx_ready,
   input logic                fifo_full,
   input logic                overrun,
   input logic [MAX_BITS-1:0] rd_data,
   input logic                rd_ferr,
   input logic                rd_brk
);

   a_r10_overrun_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      overrun && !err_clr |=> overrun);

   a_r10_overrun_when_full: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(overrun) |-> $past(fifo_full));

   a_r9_full_is_ready: assert property (@(posedge clk) disable iff (!rst_n)
      fifo_full |-> rx_ready);

   a_r5_break_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
      rx_ready && rd_brk |-> !rd_ferr && (rd_data == '0));

   a_r8_no_jump_to_full: assert property (@(posedge clk) disable iff (!rst_n)
      !rx_ready |=> !fifo_full);

endmodule

bind uart_rx_status uart_rx_status_chk #(.MAX_BITS(MAX_BITS)) u_chk (
   .clk(clk), .rst_n(rst_n), .err_clr(err_clr), .rx_ready(rx_ready),
   .fifo_full(fifo_full), .overrun(overrun), .rd_data(rd_data),
   .rd_ferr(rd_ferr), .rd_brk(rd_brk)
);

// File: tb/uart_rx_status_test.sv
`timescale 1ns/1ps
module uart_rx_status_test;

   localparam int BIT_CYC = 32;   // 16 ticks, one tick every 2 clocks
   localparam int NV = 11;
   // vector: [14:13] len code, [12:11] parity mode, [10] force level,
   //         [9:2] data, [1] flip parity, [0] stop bit level
   localparam logic [14:0] VEC [NV] = '{
      {2'd3, 2'd0, 1'b0, 8'h55, 1'b0, 1'b1},
      {2'd0, 2'd0, 1'b0, 8'hFF, 1'b0, 1'b1},
      {2'd1, 2'd1, 1'b0, 8'h2D, 1'b0, 1'b1},
      {2'd2, 2'd2, 1'b0, 8'h41, 1'b1, 1'b1},
      {2'd3, 2'd1, 1'b0, 8'hA5, 1'b1, 1'b1},
      {2'd3, 2'd3, 1'b1, 8'h00, 1'b0, 1'b1},
      {2'd3, 2'd3, 1'b0, 8'h3C, 1'b1, 1'b1},
      {2'd3, 2'd0, 1'b0, 8'h80, 1'b0, 1'b0},
      {2'd3, 2'd0, 1'b0, 8'h00, 1'b0, 1'b0},
      {2'd0, 2'd2, 1'b0, 8'h00, 1'b0, 1'b0},
      {2'd2, 2'd3, 1'b0, 8'h00, 1'b0, 1'b0}
   };

   logic       clk = 1'b0, rst_n = 1'b0, tick_16x = 1'b0, rxd = 1'b1;
   logic [1:0] cfg_len = 2'd3, cfg_par = 2'd0;
   logic       cfg_plvl = 1'b0, rd_en = 1'b0, err_clr = 1'b0;
   logic       rx_ready, fifo_full, overrun, rd_perr, rd_ferr, rd_brk;
   logic [7:0] rd_data;
   int         n_chk = 0, n_fail = 0;
   bit         done = 1'b0;

   always #5 clk = ~clk;
   always @(posedge clk) tick_16x <= rst_n ? ~tick_16x : 1'b0;

   uart_rx_status uut (
      .clk(clk), .rst_n(rst_n), .tick_16x(tick_16x), .rxd(rxd),
      .cfg_len(cfg_len), .cfg_par(cfg_par), .cfg_plvl(cfg_plvl),
      .rd_en(rd_en), .err_clr(err_clr), .rx_ready(rx_ready),
      .fifo_full(fifo_full), .overrun(overrun), .rd_data(rd_data),
      .rd_perr(rd_perr), .rd_ferr(rd_ferr), .rd_brk(rd_brk)
   );

   task automatic chk(input bit ok, input string req, input logic [31:0] act,
                      input logic [31:0] exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   function automatic logic par_of(input logic [1:0] pm, input logic lvl,
                                   input logic [7:0] d);
      case (pm)
         2'd1:    return ^d;
         2'd2:    return ~^d;
         2'd3:    return lvl;
         default: return 1'b0;
      endcase
   endfunction

   // expected {brk, ferr, perr, data}
   function automatic logic [10:0] model(input logic [14:0] v);
      logic [7:0] d = v[9:2] & 8'((9'd1 << (v[14:13] + 5)) - 9'd1);
      logic pb   = par_of(v[12:11], v[10], d) ^ v[1];
      logic pon  = (v[12:11] != 2'd0);
      logic any1 = (|d) || (pon && pb);
      return {!v[0] && !any1, !v[0] && any1, pon && v[1], d};
   endfunction

   task automatic line(input logic lvl, input int bits);
      rxd = lvl;
      repeat (bits * BIT_CYC) @(negedge clk);
   endtask

   task automatic send(input logic [14:0] v);
      logic [7:0] d = v[9:2];
      cfg_len = v[14:13]; cfg_par = v[12:11]; cfg_plvl = v[10];
      line(1'b0, 1);
      for (int i = 0; i < int'(v[14:13]) + 5; i++) line(d[i], 1);
      if (v[12:11] != 2'd0) line(par_of(v[12:11], v[10], d) ^ v[1], 1);
      line(v[0], 1);
      line(1'b1, 2);
   endtask

   task automatic pop_check(input logic [10:0] exp, input string req);
      chk(rx_ready === 1'b1, req, rx_ready, 1);
      chk({rd_brk, rd_ferr, rd_perr, rd_data} === exp, req,
          {rd_brk, rd_ferr, rd_perr, rd_data}, exp);
      rd_en = 1'b1;
      @(negedge clk);
      rd_en = 1'b0;
      @(negedge clk);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

   initial begin
      repeat (4) @(negedge clk);
      // R11: reset state
      chk(!rx_ready, "R11", rx_ready, 0);
      chk(!fifo_full, "R11", fifo_full, 0);
      chk(!overrun, "R11", overrun, 0);
      rst_n = 1'b1;
      repeat (40) @(negedge clk);

      // table: R1 length, R3 parity, R4 framing, R5 break
      for (int k = 0; k < NV; k++) begin
         send(VEC[k]);
         pop_check(model(VEC[k]), "R1/R3/R4/R5 table");
         chk(!rx_ready, "R8 single entry", rx_ready, 0);
      end

      // R2: short low glitch is not a start bit
      cfg_len = 2'd3; cfg_par = 2'd0;
      rxd = 1'b0; repeat (10) @(negedge clk);
      line(1'b1, 3);
      chk(!rx_ready, "R2 glitch", rx_ready, 0);

      // R7 + R6: break starting mid-character, long low line
      line(1'b0, 1);
      for (int i = 0; i < 8; i++) line(1'(8'h0F >> i), 1);
      line(1'b0, 24);
      chk(rx_ready, "R6 entry present", rx_ready, 1);
      line(1'b1, 2);
      pop_check({3'b010, 8'h0F}, "R7 framing entry");
      pop_check({3'b100, 8'h00}, "R7 break entry");
      chk(!rx_ready, "R6 one break slot", rx_ready, 0);

      // R8/R9/R10: fill, ninth waits, tenth overruns
      for (int i = 0; i < 8; i++) begin
         send({2'd3, 2'd0, 1'b0, 8'(8'h10 + i), 1'b0, 1'b1});
         chk(fifo_full === (i == 7), "R9 full at eight", fifo_full, i == 7);
      end
      send({2'd3, 2'd0, 1'b0, 8'h18, 1'b0, 1'b1});
      chk(!overrun, "R10 ninth waits", overrun, 0);
      send({2'd3, 2'd0, 1'b0, 8'h19, 1'b0, 1'b1});
      chk(overrun, "R10 overrun set", overrun, 1);
      pop_check({3'b000, 8'h10}, "R8 order");
      chk(fifo_full, "R9 stays full", fifo_full, 1);
      for (int i = 1; i < 8; i++) pop_check({3'b000, 8'(8'h10 + i)}, "R8 order");
      pop_check({3'b000, 8'h19}, "R10 waiting char lost");
      chk(!rx_ready && !fifo_full, "R8 empty", {rx_ready, fifo_full}, 0);
      rd_en = 1'b1; @(negedge clk); rd_en = 1'b0; @(negedge clk);
      chk(!rx_ready && !fifo_full, "R8 empty read", {rx_ready, fifo_full}, 0);
      chk(overrun, "R10 sticky", overrun, 1);
      err_clr = 1'b1; @(negedge clk); err_clr = 1'b0; @(negedge clk);
      chk(!overrun, "R10 cleared", overrun, 0);

      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

endmodule